// File: doc/BRIEF.md
# Key-Armed Watchdog Timer With Reset Pulse

This block is a watchdog for a small microcontroller core. It counts machine-cycle ticks in a 14-bit counter. If software does not service it in time, it drives a reset pulse of fixed length. It starts disabled after every reset. Software enables it by writing a two-byte key to one write-only service address on a simple register-write bus. Writing the same key again while the watchdog runs clears the counter. No write can turn it off again: only a reset, or the end of its own reset pulse, does that.

The count stops while the core is powered down. After a power-down it stays held until the wake-up interrupt line is released. An idle-hold control input decides whether the count also freezes while the core is idle. The counter value is never visible on the bus. The only output is the reset pulse.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous reset (`rst` high) the watchdog is disabled, `wdReset` is low, and ticks do not advance the count.
- R2: A write of 0x1E to address 0xA6, followed by a write of 0xE1 to address 0xA6 as the next write to that address, enables the watchdog at the clock edge that accepts the 0xE1 write, with the count at zero.
- R3: Between the two key bytes, a write to 0xA6 of any value other than 0xE1 discards the partly entered key. An exception is a further 0x1E, which restarts it. A write of 0xE1 to 0xA6 with no pending 0x1E does nothing. Writes to any other address leave a pending key untouched.
- R4: While the watchdog is enabled, a completed key clears the count to zero.
- R5: Once enabled, no bus write can disable the watchdog.
- R6: While enabled, each cycle with `tick` high adds one to the count. The cycle after the count reaches 0x3FFF, `wdReset` rises.
- R7: `wdReset` stays high for exactly 98 clock cycles. When it falls, the watchdog is disabled, the count is zero and any pending key is discarded.
- R8: While `powerDown` is high the count does not advance. After `powerDown` falls, the count stays held until `wakeIrqN` is high.
- R9: With `idleHold` at 1 the count freezes while `idle` is high and resumes from the held value afterwards. With `idleHold` at 0, idle has no effect on counting.
- R10: A reset while `wdReset` is high ends the pulse at once and returns the block to its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Machine-cycle strobe, one clock wide |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| idle | input | 1 | Core is in idle mode |
| idleHold | input | 1 | 1: freeze the count during idle |
| powerDown | input | 1 | Core is in power-down mode |
| wakeIrqN | input | 1 | Wake-up interrupt line, active low |
| wdReset | output | 1 | Watchdog reset pulse, active high |

## Verification
The assertions assume that `rst` is high at the first clock edge and that all inputs change only away from the rising edge. They also assume that a bus write lasts one clock, because a held write strobe counts as repeated writes. The stimulus drives every input on the falling edge and leaves `wrEn` high for one cycle per write. It raises `idle` and `powerDown` only in whole-cycle stretches. It never completes a key in the same cycle that the count sits at its ceiling, so that corner is left to the reference model.

// File: rtl/kw_pkg.sv
package kw_pkg;

  // Strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic cntClear;    // zero the watchdog count
    logic cntAdvance;  // add one to the watchdog count
    logic pulseStart;  // load the pulse-length counter
    logic pulseRun;    // step the pulse-length counter
  } kwStrobe_t;

endpackage

// File: rtl/kw_dpath.sv
module kw_dpath #(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 98
) (
  input  logic             clk,
  input  logic             rst,
  input  kw_pkg::kwStrobe_t strb,
  output logic [CNT_W-1:0] count,
  output logic             cntAtMax,
  output logic             pulseLast
);

  localparam int PULSE_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0]   CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [PULSE_W-1:0] PULSE_END = PULSE_W'(PULSE_LEN - 1);

  logic [PULSE_W-1:0] pulseCnt;

  // Watchdog count: a clear wins over an advance
  always_ff @(posedge clk) begin
    if (rst || strb.cntClear) begin
      count <= '0;
    end else if (strb.cntAdvance) begin
      count <= count + 1'b1;
    end
  end

  // Pulse-length counter, measured in oscillator clocks
  always_ff @(posedge clk) begin
    if (rst || strb.pulseStart) begin
      pulseCnt <= '0;
    end else if (strb.pulseRun) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  assign cntAtMax  = (count == CNT_MAX);
  assign pulseLast = (pulseCnt == PULSE_END);

endmodule

// File: rtl/kw_ctrl.sv
module kw_ctrl #(
  parameter logic [7:0] SVC_ADDR = 8'hA6,
  parameter logic [7:0] KEY_A    = 8'h1E,
  parameter logic [7:0] KEY_B    = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [7:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic              idle,
  input  logic              idleHold,
  input  logic              powerDown,
  input  logic              wakeIrqN,
  input  logic              cntAtMax,
  input  logic              pulseLast,
  output kw_pkg::kwStrobe_t strb,
  output logic              enabled,
  output logic              pulseActive
);

  logic armed;        // first key byte has been seen
  logic pdHold;       // held after power-down until the wake line is released
  logic overflowNow;
  logic keyHit;
  logic keyFire;
  logic pulseEnd;
  logic runGate;

  always_comb begin
    overflowNow = enabled && cntAtMax && !pulseActive;
    keyHit      = wrEn && (wrAddr == SVC_ADDR) && !pulseActive && !overflowNow;
    keyFire     = keyHit && (wrData == KEY_B) && armed;
    pulseEnd    = pulseActive && pulseLast;
    runGate     = enabled && tick && !powerDown && !pdHold &&
                  !(idle && idleHold) && !pulseActive;

    strb            = '0;
    strb.cntClear   = keyFire || pulseEnd;
    strb.cntAdvance = runGate && !cntAtMax;
    strb.pulseStart = overflowNow;
    strb.pulseRun   = pulseActive && !pulseLast;
  end

  // Enable flag, key tracker and pulse state
  always_ff @(posedge clk) begin
    if (rst) begin
      enabled     <= 1'b0;
      armed       <= 1'b0;
      pulseActive <= 1'b0;
    end else if (pulseEnd) begin
      enabled     <= 1'b0;
      armed       <= 1'b0;
      pulseActive <= 1'b0;
    end else begin
      if (overflowNow) pulseActive <= 1'b1;
      if (keyFire)     enabled     <= 1'b1;
      if (keyHit)      armed       <= (wrData == KEY_A);
    end
  end

  // Power-down hold, released only once the wake line is high again
  always_ff @(posedge clk) begin
    if (rst) begin
      pdHold <= 1'b0;
    end else if (powerDown) begin
      pdHold <= 1'b1;
    end else if (wakeIrqN) begin
      pdHold <= 1'b0;
    end
  end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int         CNT_W     = 14,
  parameter int         PULSE_LEN = 98,
  parameter logic [7:0] SVC_ADDR  = 8'hA6,
  parameter logic [7:0] KEY_A     = 8'h1E,
  parameter logic [7:0] KEY_B     = 8'hE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       idle,
  input  logic       idleHold,
  input  logic       powerDown,
  input  logic       wakeIrqN,
  output logic       wdReset
);

  kw_pkg::kwStrobe_t strb;
  logic [CNT_W-1:0]  count;
  logic              cntAtMax;
  logic              pulseLast;
  logic              enabled;
  logic              pulseActive;

  kw_ctrl #(
    .SVC_ADDR (SVC_ADDR),
    .KEY_A    (KEY_A),
    .KEY_B    (KEY_B)
  ) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .idle        (idle),
    .idleHold    (idleHold),
    .powerDown   (powerDown),
    .wakeIrqN    (wakeIrqN),
    .cntAtMax    (cntAtMax),
    .pulseLast   (pulseLast),
    .strb        (strb),
    .enabled     (enabled),
    .pulseActive (pulseActive)
  );

  kw_dpath #(
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN)
  ) dpath_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .count     (count),
    .cntAtMax  (cntAtMax),
    .pulseLast (pulseLast)
  );

  assign wdReset = pulseActive;

endmodule

// File: rtl/kw_checker.sv
module kw_checker #(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 98
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic             idle,
  input logic             idleHold,
  input logic             powerDown,
  input logic             wdReset,
  input logic             enabled,
  input logic [CNT_W-1:0] count
);

  // Length of the current high stretch of wdReset
  logic [15:0] hiLen;
  always_ff @(posedge clk) begin
    if (rst)          hiLen <= '0;
    else if (wdReset) hiLen <= hiLen + 1'b1;
    else              hiLen <= '0;
  end

  // R1: reset leaves the block disabled with no pulse
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!enabled && !wdReset && count == '0));

  // R5: only the end of a pulse or a reset clears the enable
  a_r5_enable_sticky: assert property (@(posedge clk) disable iff (rst)
    (enabled && !wdReset) |=> enabled);

  // R6: the count only steps up by one or returns to zero
  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0));

  // R7: a pulse that ends on its own lasts exactly PULSE_LEN clocks
  a_r7_pulse_len: assert property (@(posedge clk) disable iff (rst)
    ($fell(wdReset) && !$past(rst)) |-> (hiLen == 16'(PULSE_LEN)));

  // R7: the end of the pulse leaves the watchdog disabled
  a_r7_off_after: assert property (@(posedge clk) disable iff (rst)
    ($fell(wdReset) && !$past(rst)) |-> (!enabled && count == '0));

  // R8: power-down freezes the count
  a_r8_pd_freeze: assert property (@(posedge clk) disable iff (rst)
    (powerDown && !wrEn && !wdReset) |=> $stable(count));

  // R9: idle with the hold bit set freezes the count
  a_r9_idle_freeze: assert property (@(posedge clk) disable iff (rst)
    (idle && idleHold && !wrEn && !wdReset) |=> $stable(count));

endmodule

bind keyed_watchdog kw_checker #(
  .CNT_W     (CNT_W),
  .PULSE_LEN (PULSE_LEN)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wrEn      (wrEn),
  .idle      (idle),
  .idleHold  (idleHold),
  .powerDown (powerDown),
  .wdReset   (wdReset),
  .enabled   (enabled),
  .count     (count)
);

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic       idle = 1'b0;
  logic       idleHold = 1'b0;
  logic       powerDown = 1'b0;
  logic       wakeIrqN = 1'b1;
  logic       wdReset;

  always #5 clk = ~clk;

  keyed_watchdog dut_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .idle      (idle),
    .idleHold  (idleHold),
    .powerDown (powerDown),
    .wakeIrqN  (wakeIrqN),
    .wdReset   (wdReset)
  );

  // Behavioural reference model
  int    refEnabled = 0;
  int    refCount   = 0;
  int    refArmed   = 0;
  int    refLeft    = 0;
  int    refPdHold  = 0;
  int    vectors    = 0;
  int    miscompares = 0;
  bit    done = 0;
  string curReq = "R1";

  always @(posedge clk) begin
    int oldPd;
    oldPd = refPdHold;
    if (rst) begin
      refEnabled = 0; refCount = 0; refArmed = 0; refLeft = 0;
    end else if (refLeft > 0) begin
      refLeft = refLeft - 1;
      if (refLeft == 0) begin
        refEnabled = 0; refCount = 0; refArmed = 0;
      end
    end else if (refEnabled != 0 && refCount == 16383) begin
      refLeft = 98;
    end else begin
      bit fired;
      fired = 0;
      if (wrEn && wrAddr == 8'hA6) begin
        if (wrData == 8'hE1 && refArmed != 0) fired = 1;
        refArmed = (wrData == 8'h1E) ? 1 : 0;
      end
      if (fired) begin
        refEnabled = 1;
        refCount = 0;
      end else if (refEnabled != 0 && tick && !powerDown && oldPd == 0 &&
                   !(idle && idleHold)) begin
        refCount = refCount + 1;
      end
    end
    if (rst)            refPdHold = 0;
    else if (powerDown) refPdHold = 1;
    else if (wakeIrqN)  refPdHold = 0;
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit expPulse;
      expPulse = (refLeft > 0);
      vectors++;
      if (wdReset !== expPulse) begin
        miscompares++;
        $display("FAIL %s: wdReset=%b expected %b at %0t", curReq, wdReset, expPulse, $time);
      end
    end
  end

  task automatic run(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = ((i % every) == 0);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; tick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    // R1: reset state, and ticks without a key do nothing
    curReq = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    run(300, 1);

    // R3: lone second byte, interrupted key, foreign-address write
    curReq = "R3";
    busWrite(8'hA6, 8'hE1);
    busWrite(8'hA6, 8'h1E);
    busWrite(8'hA6, 8'h55);
    busWrite(8'hA6, 8'hE1);
    run(50, 1);
    // R2: key split by a write elsewhere still enables
    curReq = "R2";
    busWrite(8'hA6, 8'h1E);
    busWrite(8'h10, 8'hE1);
    busWrite(8'hA6, 8'hE1);
    run(5000, 1);

    // R4: service clears the count
    curReq = "R4";
    busWrite(8'hA6, 8'h1E);
    busWrite(8'hA6, 8'hE1);
    run(3000, 1);

    // R5: stray writes cannot disable
    curReq = "R5";
    busWrite(8'hA6, 8'h00);
    busWrite(8'hA6, 8'hFF);
    busWrite(8'hA6, 8'h1E);
    busWrite(8'h20, 8'h00);
    run(1000, 1);

    // R9: idle with and without the hold bit
    curReq = "R9";
    idleHold = 1'b1; idle = 1'b1;
    run(1500, 1);
    idle = 1'b0;
    run(200, 1);
    idleHold = 1'b0; idle = 1'b1;
    run(500, 1);
    idle = 1'b0;

    // R8: power-down, then held while the wake line is low
    curReq = "R8";
    wakeIrqN = 1'b0; powerDown = 1'b1;
    run(800, 1);
    powerDown = 1'b0;
    run(400, 1);
    wakeIrqN = 1'b1;
    run(100, 1);

    // R6: sparse ticks, then run to overflow
    curReq = "R6";
    run(2000, 2);
    run(14000, 1);
    // R7: pulse length, then the watchdog is disabled
    curReq = "R7";
    busWrite(8'hA6, 8'hE1);
    run(17000, 1);

    // R10: reset in the middle of a pulse
    curReq = "R10";
    busWrite(8'hA6, 8'h1E);
    busWrite(8'hA6, 8'hE1);
    run(16420, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    run(300, 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule